// File: doc/BRIEF.md
# Slave FIFO Burst Writer with Packet Closing

This block sits on the FPGA side of a synchronous slave FIFO link to a USB bridge. It takes a transfer length in 32-bit words and a valid/ready word stream. It moves the words onto the bridge's data bus under active-low chip select, write strobe and packet-end strobe. The bridge reports free buffer space on a ready flag and room for a burst on a watermark flag. The writer paces itself from these two flags.

The writer closes every transfer so that a host read waiting on the pipe completes. A length that is not a whole number of 1024-byte packets (256 words) is closed by raising packet-end together with the final write. A whole-packet length is closed in one of two ways. The first is a separate zero-length-packet strobe, issued after a guard interval and only once the ready flag is high. The second, selected at start, splits the final full packet into two short packets.

Stream rules: a word moves in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while a transfer is moving data and the ready flag is high. The source may drop `in_valid` at any time, and no write is made in that cycle. Data is taken in stream order.

Top module: `usb_fifo_writer`

## Requirements
- R1: In reset and whenever `busy` is low, `bus_cs_n`, `bus_wr_n` and `bus_end_n` are all high. After reset, `busy` and `done` are low.
- R2: While a transfer is moving data and both `bridge_rdy` and `bridge_wm` are high, `in_ready` is high and one word is written on every clock that `in_valid` is high.
- R3: A write made while `bridge_wm` is low is followed by SETTLE_CYC (default 4) cycles with no write, so the gap between consecutive throttled writes is SETTLE_CYC+1 cycles.
- R4: No strobe is asserted in a cycle where `bridge_rdy` is low. `bus_cs_n` low implies `bridge_rdy` high, and `in_ready` is low whenever `bridge_rdy` is low.
- R5: For a length that is not a multiple of 256 words, `bus_end_n` is low in the cycle of the final write, and only then. No zero-length strobe follows.
- R6: For a nonzero multiple of 256 words with split mode off, no write has `bus_end_n` low. A zero-length strobe (`bus_cs_n` and `bus_end_n` low, `bus_wr_n` high, one cycle) comes GUARD_CYC+1 cycles after the final write when `bridge_rdy` stays high.
- R7: The zero-length strobe waits for `bridge_rdy`. It is issued in the first cycle, after the guard, in which `bridge_rdy` is high.
- R8: After the zero-length strobe, the bus stays idle and `busy` stays high for POST_CYC cycles. `done` is high POST_CYC+1 cycles after the strobe.
- R9: With `split_mode` high at start and a nonzero multiple of 256 words, `bus_end_n` is low with the write of word len-128 and with the write of word len, and no zero-length strobe is issued.
- R10: A start with length 0 gives exactly one zero-length strobe and no writes.
- R11: `start` is taken only when idle, and it latches `len_words` and `split_mode`. `busy` is high from the cycle after start until the closing sequence ends. Then `done` is high for exactly one cycle with `busy` low. A start while busy has no effect.
- R12: The words written equal the accepted stream words in order, with no word lost or repeated. The number written equals the latched length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the bridge port |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transfer (taken when idle) |
| len_words | input | 16 | Transfer length in 32-bit words |
| split_mode | input | 1 | 1: close whole-packet lengths with two short packets |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer has closed |
| in_valid | input | 1 | Stream word valid |
| in_data | input | 32 | Stream word |
| in_ready | output | 1 | Writer takes the word this cycle |
| bridge_rdy | input | 1 | Bridge has free buffer space |
| bridge_wm | input | 1 | Bridge has room for a burst |
| bus_data | output | 32 | Data to the bridge |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_end_n | output | 1 | Packet-end strobe, active low |

## Verification
Some rules hold on every cycle, and the embedded assertions check those:
- no strobe while the ready flag is low;
- the idle bus outside a transfer;
- the quiet cycle after a throttled write;
- the idle cycle that follows a zero-length strobe;
- the single-cycle done pulse.

Other behaviour is shown only by the directed scenarios, because it depends on the length seen over a whole transfer:
- which write carries packet-end in each closing mode;
- the exact cycle distance from the final word to the zero-length strobe and to `done`;
- the in-order word count;
- the deferral of the strobe until the ready flag returns.

// File: rtl/slw_pkg.sv
package slw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_SETTLE,
    ST_GUARD,
    ST_WAITRDY,
    ST_POST,
    ST_DONE
  } slw_state_e;
endpackage

// File: rtl/slw_wait_timer.sv
module slw_wait_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/slw_len_tracker.sv
module slw_len_tracker #(
  parameter int LEN_W     = 16,
  parameter int PKT_WORDS = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             split_in,
  input  logic             step,
  output logic             last_word,
  output logic             split_point,
  output logic             whole_pkt,
  output logic             split_on
);
  localparam int PKT_LOG = $clog2(PKT_WORDS);
  localparam int HALF    = PKT_WORDS / 2;

  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain    <= '0;
      whole_pkt <= 1'b0;
      split_on  <= 1'b0;
    end else if (load) begin
      remain    <= len_in;
      whole_pkt <= (len_in[PKT_LOG-1:0] == '0) && (len_in != '0);
      split_on  <= split_in;
    end else if (step) begin
      remain <= remain - 1'b1;
    end
  end

  assign last_word   = (remain == LEN_W'(1));
  assign split_point = (remain == LEN_W'(HALF + 1));

  // R12
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> (remain != '0));
endmodule

// File: rtl/usb_fifo_writer.sv
module usb_fifo_writer
  import slw_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PKT_BYTES  = 1024,
  parameter int LEN_W      = 16,
  parameter int SETTLE_CYC = 4,
  parameter int GUARD_CYC  = 4,
  parameter int POST_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_words,
  input  logic              split_mode,
  output logic              busy,
  output logic              done,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              bridge_rdy,
  input  logic              bridge_wm,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_cs_n,
  output logic              bus_wr_n,
  output logic              bus_end_n
);
  localparam int PKT_WORDS = PKT_BYTES / (DATA_W / 8);
  localparam int MAX_A     = (SETTLE_CYC > GUARD_CYC) ? SETTLE_CYC : GUARD_CYC;
  localparam int MAX_WAIT  = (MAX_A > POST_CYC) ? MAX_A : POST_CYC;
  localparam int CNT_W     = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT);

  slw_state_e       state, nxt;
  logic             fire, zlp_now, end_with_word;
  logic             t_load, t_zero;
  logic [CNT_W-1:0] t_val;
  logic             last_word, split_point, whole_pkt, split_on;
  logic             take_start;

  assign take_start = start && (state == ST_IDLE);

  slw_len_tracker #(.LEN_W(LEN_W), .PKT_WORDS(PKT_WORDS)) u_len (
    .clk(clk), .rst(rst), .load(take_start), .len_in(len_words),
    .split_in(split_mode), .step(fire), .last_word(last_word),
    .split_point(split_point), .whole_pkt(whole_pkt), .split_on(split_on)
  );

  slw_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_zero)
  );

  // Bus and stream side, decoded from state and live flags
  assign in_ready      = (state == ST_XFER) && bridge_rdy;
  assign fire          = in_valid && in_ready;
  assign zlp_now       = (state == ST_WAITRDY) && bridge_rdy;
  assign end_with_word = fire && ((last_word && !(whole_pkt && !split_on)) ||
                                  (whole_pkt && split_on && split_point));
  assign bus_data      = in_data;
  assign bus_cs_n      = !(fire || zlp_now);
  assign bus_wr_n      = !fire;
  assign bus_end_n     = !(end_with_word || zlp_now);
  assign busy          = (state != ST_IDLE) && (state != ST_DONE);
  assign done          = (state == ST_DONE);

  always_comb begin
    nxt    = state;
    t_load = 1'b0;
    t_val  = '0;
    unique case (state)
      ST_IDLE:
        if (take_start) nxt = (len_words == '0) ? ST_WAITRDY : ST_XFER;
      ST_XFER:
        if (fire) begin
          if (last_word) begin
            if (whole_pkt && !split_on) begin
              nxt = ST_GUARD; t_load = 1'b1; t_val = CNT_W'(GUARD_CYC - 1);
            end else begin
              nxt = ST_DONE;
            end
          end else if (end_with_word || !bridge_wm) begin
            nxt = ST_SETTLE; t_load = 1'b1; t_val = CNT_W'(SETTLE_CYC - 1);
          end
        end
      ST_SETTLE:  if (t_zero) nxt = ST_XFER;
      ST_GUARD:   if (t_zero) nxt = ST_WAITRDY;
      ST_WAITRDY:
        if (bridge_rdy) begin
          nxt = ST_POST; t_load = 1'b1; t_val = CNT_W'(POST_CYC - 1);
        end
      ST_POST:    if (t_zero) nxt = ST_DONE;
      ST_DONE:    nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  // R4
  rdy_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_cs_n |-> bridge_rdy);
  // R3
  throttle_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr_n && !bridge_wm) |=> bus_wr_n);
  // R8
  post_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_end_n && bus_wr_n) |=> (bus_cs_n && busy));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (bus_cs_n && bus_wr_n && bus_end_n));
endmodule

// File: tb/usb_fifo_writer_bench.sv
module usb_fifo_writer_bench;
  localparam int SETTLE = 4, GUARD = 4, POST = 4;
  localparam logic [31:0] BASE = 32'hA500_0000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, split_mode = 1'b0;
  logic [15:0] len_words = '0;
  logic busy, done, in_valid = 1'b0, in_ready, bridge_rdy = 1'b1, bridge_wm = 1'b1;
  logic [31:0] in_data = '0, bus_data;
  logic bus_cs_n, bus_wr_n, bus_end_n;

  always #4 clk = ~clk;

  usb_fifo_writer u_usb_fifo_writer (
    .clk(clk), .rst(rst), .start(start), .len_words(len_words), .split_mode(split_mode),
    .busy(busy), .done(done), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .bridge_rdy(bridge_rdy), .bridge_wm(bridge_wm), .bus_data(bus_data),
    .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_end_n(bus_end_n)
  );

  int nchk = 0, nerr = 0;
  int cyc = 0;
  // requests from tasks, applied by the driver process
  bit start_req = 0, split_sel = 0, wm_sel = 1, gap_mode = 0, restart_pending = 0;
  int len_sel = 0, drop_at = -1, drop_len = 0;
  // monitor state
  int src_idx, nwr, nend, zlp_cnt, zlp_cyc, last_wr_cyc, done_cnt, done_cyc;
  int min_gap, max_gap, bad_rdy, data_err, busy_gap, rise_cyc, start_cyc, hold;
  int end_pos[4];
  bit acc_prev, run_active, prev_rdy;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    src_idx = 0; nwr = 0; nend = 0; zlp_cnt = 0; zlp_cyc = -1; last_wr_cyc = -1;
    done_cnt = 0; done_cyc = -1; min_gap = 1 << 30; max_gap = 0; bad_rdy = 0;
    data_err = 0; busy_gap = 0; rise_cyc = -1; hold = 0; acc_prev = 0;
    run_active = 0; start_cyc = -1;
    foreach (end_pos[i]) end_pos[i] = -1;
  endtask

  // Driver at negedge, sampler two ns later (well before the next posedge)
  always @(negedge clk) begin
    cyc++;
    if (acc_prev) src_idx++;
    start = 1'b0;
    if (start_req) begin
      start = 1'b1; len_words = 16'(len_sel); split_mode = split_sel;
      start_req = 0; run_active = 1; start_cyc = cyc;
    end else if (restart_pending && nwr == 50) begin
      start = 1'b1; len_words = 16'd7; restart_pending = 0;
    end
    if (drop_at >= 0 && nwr == drop_at) begin
      hold = drop_len; drop_at = -1;
    end
    bridge_rdy = (hold == 0);
    if (hold > 0) hold--;
    if (bridge_rdy && !prev_rdy) rise_cyc = cyc;
    prev_rdy = bridge_rdy;
    bridge_wm = wm_sel;
    in_valid = gap_mode ? cyc[0] : 1'b1;
    in_data = BASE + 32'(src_idx);
    #2;
    if (!bus_cs_n && !bridge_rdy) bad_rdy++;
    if (in_ready && !bridge_rdy) bad_rdy++;
    if (!bus_cs_n && !bus_wr_n) begin
      if (bus_data !== BASE + 32'(nwr)) data_err++;
      nwr++;
      if (last_wr_cyc >= 0) begin
        if (cyc - last_wr_cyc < min_gap) min_gap = cyc - last_wr_cyc;
        if (cyc - last_wr_cyc > max_gap) max_gap = cyc - last_wr_cyc;
      end
      last_wr_cyc = cyc;
      if (!bus_end_n) begin
        if (nend < 4) end_pos[nend] = nwr;
        nend++;
      end
    end
    if (!bus_cs_n && bus_wr_n && !bus_end_n) begin
      zlp_cnt++; zlp_cyc = cyc;
    end
    if (run_active && cyc > start_cyc && !busy && !done) busy_gap++;
    if (done) begin
      done_cnt++; done_cyc = cyc; run_active = 0;
    end
    acc_prev = in_valid && in_ready;
  end

  task automatic run_xfer(input int len, input bit split);
    @(posedge clk);
    clear_stats();
    split_sel = split; len_sel = len; start_req = 1;
    for (int i = 0; i < 8000 && done_cnt == 0; i++) @(posedge clk);
    repeat (12) @(posedge clk);
    chk(done_cnt == 1, "R11 done pulses", done_cnt, 1);
    chk(busy_gap == 0, "R11 busy held", busy_gap, 0);
  endtask

  task automatic t_reset();
    @(negedge clk); #2;
    chk(bus_cs_n && bus_wr_n && bus_end_n, "R1 strobes in reset",
        {bus_cs_n, bus_wr_n, bus_end_n}, 7);
    chk(!busy && !done, "R1 busy/done in reset", {busy, done}, 0);
  endtask

  task automatic t_short_burst();
    wm_sel = 1; restart_pending = 1;
    run_xfer(300, 0);
    chk(nwr == 300, "R12 word count (R11 restart ignored)", nwr, 300);
    chk(data_err == 0, "R12 data order", data_err, 0);
    chk(max_gap == 1, "R2 burst one per cycle", max_gap, 1);
    chk(nend == 1 && end_pos[0] == 300, "R5 end on final word", end_pos[0], 300);
    chk(zlp_cnt == 0, "R5 no zlp", zlp_cnt, 0);
  endtask

  task automatic t_whole_zlp();
    wm_sel = 1;
    run_xfer(512, 0);
    chk(nwr == 512, "R6 words", nwr, 512);
    chk(nend == 0, "R6 no end with write", nend, 0);
    chk(zlp_cnt == 1, "R6 one zlp", zlp_cnt, 1);
    chk(zlp_cyc - last_wr_cyc == GUARD + 1, "R6 guard", zlp_cyc - last_wr_cyc, GUARD + 1);
    chk(done_cyc - zlp_cyc == POST + 1, "R8 post idle", done_cyc - zlp_cyc, POST + 1);
  endtask

  task automatic t_zlp_wait();
    wm_sel = 1; drop_at = 256; drop_len = 20;
    run_xfer(256, 0);
    chk(zlp_cnt == 1 && zlp_cyc == rise_cyc, "R7 zlp at ready return", zlp_cyc, rise_cyc);
    chk(bad_rdy == 0, "R4 nothing while not ready", bad_rdy, 0);
  endtask

  task automatic t_split();
    wm_sel = 1;
    run_xfer(512, 1);
    chk(nwr == 512, "R9 words", nwr, 512);
    chk(nend == 2 && end_pos[0] == 384, "R9 first short end", end_pos[0], 384);
    chk(end_pos[1] == 512, "R9 second short end", end_pos[1], 512);
    chk(zlp_cnt == 0, "R9 no zlp", zlp_cnt, 0);
  endtask

  task automatic t_zero();
    run_xfer(0, 0);
    chk(nwr == 0, "R10 no writes", nwr, 0);
    chk(zlp_cnt == 1, "R10 one zlp", zlp_cnt, 1);
  endtask

  task automatic t_throttle();
    wm_sel = 0;
    run_xfer(10, 0);
    chk(min_gap == SETTLE + 1 && max_gap == SETTLE + 1, "R3 throttled gap", min_gap, SETTLE + 1);
    chk(nwr == 10 && end_pos[0] == 10, "R5 end on final throttled word", end_pos[0], 10);
    wm_sel = 1;
  endtask

  task automatic t_stall();
    gap_mode = 1; drop_at = 20; drop_len = 7;
    run_xfer(40, 0);
    chk(nwr == 40, "R12 count with gaps", nwr, 40);
    chk(data_err == 0, "R12 order with gaps", data_err, 0);
    chk(bad_rdy == 0, "R4 stall respected", bad_rdy, 0);
    gap_mode = 0;
  endtask

  initial begin
    clear_stats();
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst = 1'b0;
    t_short_burst();
    t_whole_zlp();
    t_zlp_wait();
    t_split();
    t_zero();
    t_throttle();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(8 * 190000);
    nchk++; nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule